// File: doc/BRIEF.md
# Single-Wire Autobaud Reply Engine

This block sits on the device end of one shared open-drain wire that has an external pull-up. A host starts a transaction by holding the wire low for a while. The block counts how long that low pulse lasts in system-clock cycles and uses the count as the bit time for its answer. When the pulse ends, the block asks an acquisition unit for a sample through a start/done handshake. It then returns the 16-bit result as two asynchronous serial frames on the same wire, with a programmable idle gap between them.

The block never drives the wire high. Its single line output means "pull low"; when that output is deasserted, the pull-up restores the idle level. The wire input passes through a synchroniser before any logic uses it. While the block is waiting for the acquisition or sending its answer, it disregards everything it sees on the wire, including its own transmitted bits.

The gap setting is an 8-bit code G. The idle time between the two frames follows (10 + 4·G)/1.2 µs, which the block scales to clock cycles with a numerator/denominator pair that is fixed at build time.

Top module: `sw_autobaud_responder`

## Requirements
- R1: After reset, `line_drive_low` and `acq_start` are 0. The wire is never pulled low while the block is idle, waiting for the acquisition, or in the inter-frame gap.
- R2: A synchronised low pulse of at least MIN_PULSE (default 16) cycles produces exactly one `acq_start` pulse, one cycle long, after the wire returns high.
- R3: Every bit of the reply lasts exactly W clock cycles, where W is the number of clock cycles the trigger pulse was low.
- R4: Frame encoding: each reply frame is a start bit (`line_drive_low`=1), then eight data bits sent least significant bit first (data 1 = released, 0 = pulled low), then one released stop bit. The first frame carries `acq_result[15:8]` and the second carries `acq_result[7:0]`, both captured in the cycle `acq_done` is high.
- R5: The time from the first frame's start edge to the second frame's start edge is 10·W + floor((10 + 4·G)·GAP_NUM / GAP_DEN) cycles. G is the `gap_code` value sampled when the trigger pulse ends; later changes do not affect it. The defaults are GAP_NUM=625 and GAP_DEN=6, which gives µs at 125 MHz.
- R6: A low pulse shorter than MIN_PULSE cycles starts no acquisition and produces no reply.
- R7: The pulse counter saturates at 2^16−1. A pulse that is still low after reaching that count starts no acquisition and produces no reply. Once the wire is high again, the block is idle and accepts the next valid pulse.
- R8: Activity on the wire while the block is waiting for the acquisition or replying (host pulses and the block's own bits) starts no new acquisition.
- R9: The block returns to idle with the wire released only after the second stop bit has completed, and then accepts a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared wire (asynchronous) |
| line_drive_low | output | 1 | 1 = pull the wire low, 0 = release it |
| acq_start | output | 1 | One-cycle request to the acquisition unit |
| acq_done | input | 1 | One-cycle acknowledgement that the result is valid |
| acq_result | input | 16 | Acquisition result to transmit |
| gap_code | input | 8 | Inter-frame gap code G |

## Verification
A wrong measured width shows at the wire immediately: every bit of the reply stretches or shrinks, and the distance between the two start edges moves by ten times the error. A gap-counter fault shows only in that start-to-start distance, and only after the first frame's full ten bits have gone out. A fault in the disarming of the measurement shows as an extra acquisition request within a few cycles of a host pulse made during the busy period. An overflow or glitch-filter fault shows as a reply, or as missing `acq_start` activity, within a few cycles after the wire rises.

// File: rtl/swar_pkg.sv
package swar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACQ   = 3'd1,
    ST_TX_HI = 3'd2,
    ST_GAP   = 3'd3,
    ST_TX_LO = 3'd4
  } resp_state_e;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;

  // Gap units for the largest code: 10 + 4*(2^code_w - 1)
  function automatic longint gap_units_max(input int code_w);
    return 64'd10 + 64'd4 * ((64'd1 << code_w) - 64'd1);
  endfunction

  function automatic int gap_prod_width(input int code_w, input int num);
    return $clog2(gap_units_max(code_w) * num + 1);
  endfunction

  function automatic int gap_width(input int code_w, input int num, input int den);
    return $clog2(gap_units_max(code_w) * num / den + 1);
  endfunction

endpackage

// File: rtl/swar_sync.sv
module swar_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swar_pulse_meter.sv
module swar_pulse_meter #(
  parameter int CNT_W     = 16,
  parameter int MIN_PULSE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             line_s,
  output logic             trig,
  output logic [CNT_W-1:0] width,
  output logic             active,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_PULSE);

  logic ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      count  <= '0;
      ovf    <= 1'b0;
      trig   <= 1'b0;
      width  <= '0;
    end else begin
      trig <= 1'b0;
      if (!arm) begin
        active <= 1'b0;
        ovf    <= 1'b0;
        count  <= '0;
      end else if (!active) begin
        if (!line_s) begin
          active <= 1'b1;
          count  <= CNT_W'(1);
          ovf    <= 1'b0;
        end
      end else if (!line_s) begin
        if (count == CNT_MAX) ovf <= 1'b1;      // saturate, mark abort
        else                  count <= count + 1'b1;
      end else begin
        active <= 1'b0;
        if (!ovf && count >= MIN_L) begin
          trig  <= 1'b1;
          width <= count;
        end
      end
    end
  end
endmodule

// File: rtl/swar_gap_calc.sv
module swar_gap_calc #(
  parameter int CODE_W  = 8,
  parameter int GAP_NUM = 625,
  parameter int GAP_DEN = 6,
  parameter int GAP_W   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic [GAP_W-1:0]  gap_cycles
);
  localparam int PROD_W = swar_pkg::gap_prod_width(CODE_W, GAP_NUM);

  logic [PROD_W-1:0] units, prod, quo;

  always_comb begin
    units = PROD_W'(10) + (PROD_W'(code) << 2);
    prod  = units * PROD_W'(GAP_NUM);
    quo   = prod / PROD_W'(GAP_DEN);
  end

  always_ff @(posedge clk) begin
    if (rst)       gap_cycles <= '0;
    else if (load) gap_cycles <= quo[GAP_W-1:0];
  end
endmodule

// File: rtl/swar_frame_tx.sv
module swar_frame_tx #(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go,
  input  logic [swar_pkg::BYTE_W-1:0] data,
  input  logic [CNT_W-1:0]           period,
  output logic                       drive_low,
  output logic                       done
);
  localparam int NB    = swar_pkg::FRAME_BITS;
  localparam int IDX_W = $clog2(NB);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic [NB-1:0]    shreg;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] timer;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '1;
      idx       <= '0;
      timer     <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        shreg     <= {1'b1, data, 1'b0};
        idx       <= '0;
        timer     <= period - 1'b1;
        busy      <= 1'b1;
        drive_low <= 1'b1;
      end else if (busy) begin
        if (timer != '0) begin
          timer <= timer - 1'b1;
        end else if (idx == LAST) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          drive_low <= 1'b0;
        end else begin
          shreg     <= {1'b1, shreg[NB-1:1]};
          idx       <= idx + 1'b1;
          timer     <= period - 1'b1;
          drive_low <= ~shreg[1];
        end
      end
    end
  end
endmodule

// File: rtl/sw_autobaud_responder.sv
module sw_autobaud_responder #(
  parameter int CNT_W       = 16,
  parameter int MIN_PULSE   = 16,
  parameter int CODE_W      = 8,
  parameter int GAP_NUM     = 625,
  parameter int GAP_DEN     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              acq_start,
  input  logic              acq_done,
  input  logic [15:0]       acq_result,
  input  logic [CODE_W-1:0] gap_code
);
  import swar_pkg::*;

  localparam int GAP_W = gap_width(CODE_W, GAP_NUM, GAP_DEN);
  // tx_done, state change and tx_go each add one register between frames
  localparam logic [GAP_W-1:0] GAP_LEAD = GAP_W'(3);

  resp_state_e       state;
  logic              line_s;
  logic              meas_trig, meas_active;
  logic [CNT_W-1:0]  meas_width, meas_cnt;
  logic [CNT_W-1:0]  period;
  logic [GAP_W-1:0]  gap_cycles, gap_cnt;
  logic [BYTE_W-1:0] lo_byte, tx_byte;
  logic              tx_go, tx_done;
  logic              arm, gap_load;

  assign arm      = (state == ST_IDLE);
  assign gap_load = arm && meas_trig;

  swar_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  swar_pulse_meter #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE)) u_meter (
    .clk(clk), .rst(rst), .arm(arm), .line_s(line_s),
    .trig(meas_trig), .width(meas_width), .active(meas_active), .count(meas_cnt)
  );

  swar_gap_calc #(.CODE_W(CODE_W), .GAP_NUM(GAP_NUM), .GAP_DEN(GAP_DEN), .GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .code(gap_code), .gap_cycles(gap_cycles)
  );

  swar_frame_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .data(tx_byte), .period(period),
    .drive_low(line_drive_low), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      period    <= '0;
      lo_byte   <= '0;
      tx_byte   <= '0;
      tx_go     <= 1'b0;
      acq_start <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      acq_start <= 1'b0;
      tx_go     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (meas_trig) begin
            period    <= meas_width;
            acq_start <= 1'b1;
            state     <= ST_ACQ;
          end
        end
        ST_ACQ: begin
          if (acq_done) begin
            tx_byte <= acq_result[15:8];
            lo_byte <= acq_result[7:0];
            tx_go   <= 1'b1;
            state   <= ST_TX_HI;
          end
        end
        ST_TX_HI: begin
          if (tx_done) begin
            gap_cnt <= (gap_cycles > GAP_LEAD) ? gap_cycles - GAP_LEAD : '0;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            tx_byte <= lo_byte;
            tx_go   <= 1'b1;
            state   <= ST_TX_LO;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_TX_LO: begin
          if (tx_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swar_checker.sv
module swar_checker #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input swar_pkg::resp_state_e state,
  input logic                  line_drive_low,
  input logic                  acq_start,
  input logic                  meas_active,
  input logic [CNT_W-1:0]      meas_cnt,
  input logic                  tx_done
);
  import swar_pkg::*;

  // R1
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_ACQ || state == ST_GAP) |-> !line_drive_low);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> !acq_start);

  // R8
  start_source_chk: assert property (@(posedge clk) disable iff (rst)
    acq_start |-> (state == ST_ACQ && $past(state) == ST_IDLE));

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_active && $past(meas_active)) |-> (meas_cnt >= $past(meas_cnt)));

  // R9
  idle_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_LO && tx_done) |=> (state == ST_IDLE && !line_drive_low));
endmodule

bind sw_autobaud_responder swar_checker #(.CNT_W(CNT_W)) u_swar_checker (
  .clk(clk), .rst(rst), .state(state), .line_drive_low(line_drive_low),
  .acq_start(acq_start), .meas_active(meas_active), .meas_cnt(meas_cnt),
  .tx_done(tx_done)
);

// File: tb/sw_autobaud_responder_bench.sv
`timescale 1ns/1ps
module sw_autobaud_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_low = 1'b0;
  logic        line_in, line_drive_low, acq_start, acq_done;
  logic [15:0] acq_result;
  logic [7:0]  gap_code = 8'd0;

  int     n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  int     n_starts = 0, drive_cycles = 0;
  int     lat_cnt = 0, cur_lat = 200;
  logic [15:0] cur_res = 16'h0;

  // W[55:40] G[39:32] result[31:16] latency[15:0]
  localparam logic [55:0] VEC [4] = '{
    {16'd20, 8'd0, 16'hA55A, 16'd200},
    {16'd33, 8'd1, 16'h0001, 16'd200},
    {16'd64, 8'd2, 16'hFF00, 16'd200},
    {16'd17, 8'd0, 16'h8130, 16'd200}
  };

  always #4 clk = ~clk;

  assign line_in    = !(line_drive_low || host_low);
  assign acq_result = cur_res;

  sw_autobaud_responder u_sw_autobaud_responder (
    .clk(clk), .rst(rst), .line_in(line_in), .line_drive_low(line_drive_low),
    .acq_start(acq_start), .acq_done(acq_done), .acq_result(acq_result),
    .gap_code(gap_code)
  );

  // acquisition model and port monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (line_drive_low) drive_cycles <= drive_cycles + 1;
    if (rst) begin
      lat_cnt  <= 0;
      acq_done <= 1'b0;
    end else begin
      acq_done <= 1'b0;
      if (acq_start) begin
        n_starts <= n_starts + 1;
        lat_cnt  <= cur_lat;
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) acq_done <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic host_pulse(input int w);
    host_low = 1'b1;
    repeat (w) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic rx_frame(input int w, output logic [7:0] b, output longint t);
    int off, tgt;
    while (!line_drive_low) @(negedge clk);
    t = cyc;
    off = 0;
    tgt = w - 1;
    repeat (tgt - off) @(negedge clk);
    off = tgt;
    chk("R3", "start bit still low at its last cycle", line_drive_low, 1);
    for (int i = 0; i < 8; i++) begin
      tgt = (i + 1) * w + w / 2;
      repeat (tgt - off) @(negedge clk);
      off = tgt;
      b[i] = !line_drive_low;
    end
    tgt = 9 * w + w / 2;
    repeat (tgt - off) @(negedge clk);
    chk("R4", "stop bit released", line_drive_low, 0);
  endtask

  function automatic longint gap_expect(input int g);
    return ((10 + 4 * g) * 625) / 6;
  endfunction

  task automatic run_vector(input int w, input int g, input logic [15:0] res,
                            input int lat, input string tag);
    logic [7:0] hi, lo;
    longint t1, t2;
    int s0;
    gap_code = 8'(g);
    cur_res  = res;
    cur_lat  = lat;
    s0 = n_starts;
    host_pulse(w);
    repeat (10) @(negedge clk);
    gap_code = 8'hFF;          // R5: late change must not matter
    host_pulse(25);            // R8: host activity while busy
    rx_frame(w, hi, t1);
    rx_frame(w, lo, t2);
    chk("R4", {tag, " high byte first"}, hi, res[15:8]);
    chk("R4", {tag, " low byte second"}, lo, res[7:0]);
    chk("R5", {tag, " start-to-start interval"}, t2 - t1, 10 * w + gap_expect(g));
    repeat (w + 5) @(negedge clk);
    chk("R2", {tag, " one acquisition per trigger"}, n_starts - s0, 1);
    chk("R8", {tag, " no extra acquisition from busy activity"}, n_starts - s0, 1);
    chk("R9", {tag, " wire released after second stop"}, line_drive_low, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int s0, d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset: wire released", line_drive_low, 0);
    chk("R1", "reset: no acquisition request", acq_start, 0);

    for (int v = 0; v < 4; v++) begin
      run_vector(int'(VEC[v][55:40]), int'(VEC[v][39:32]), VEC[v][31:16],
                 int'(VEC[v][15:0]), $sformatf("vec%0d", v));
    end

    // R6: one cycle below the minimum
    s0 = n_starts; d0 = drive_cycles;
    host_pulse(15);
    repeat (300) @(negedge clk);
    chk("R6", "short pulse: no acquisition", n_starts - s0, 0);
    chk("R6", "short pulse: no reply", drive_cycles - d0, 0);

    // R7: pulse past counter saturation
    s0 = n_starts; d0 = drive_cycles;
    host_pulse(70000);
    repeat (300) @(negedge clk);
    chk("R7", "overlong pulse: no acquisition", n_starts - s0, 0);
    chk("R7", "overlong pulse: no reply", drive_cycles - d0, 0);

    // R7 R9: recovery with a pulse exactly at the minimum
    run_vector(16, 0, 16'h3CC3, 50, "R7 recovery at minimum width");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule